// File: doc/BRIEF.md
# Color-Tagged Prediction Table with Speculative Recoloring

This block is a small direct-mapped table of stored prediction values. Each entry has an 8-bit color tag beside its value. A lookup returns the value only when the stored tag equals the color of the requester. As a result, one thread's training never steers another thread's predictions. Privileged code uses a reserved black color that unprivileged requests may never carry.

Writes made under open speculation are not tagged with the thread color. They take a provisional white color, and each checkpoint has its own white variant. A resolve broadcast rewrites every entry that holds the named variant in one cycle. On acceptance the entry takes the color of the thread that opened the checkpoint. On rejection the entry is marked cleaned and can never hit again. A small per-checkpoint register records the owning color from the speculative updates.

Top module: `hue_pred_table`

## Requirements
- R1: After reset every entry holds the cleaned color 0x00. No lookup hits, `lk_value` is 0 and `up_err` is 0.
- R2: A legal non-speculative update (`up_spec`=0) stores its value with `up_color`. A lookup of the same index and color in a later cycle gives `lk_hit`=1 and the stored value, one cycle after the request.
- R3: A lookup whose color differs from the stored tag, or any cycle with no lookup, gives `lk_hit`=0 and `lk_value`=0 on the next cycle.
- R4: An update is illegal in any of these cases, and is then dropped with a one-cycle `up_err` pulse on the next cycle, leaving the entry unchanged:
  - unprivileged and carrying black (0xFF);
  - unprivileged and carrying cleaned (0x00) or a white value (0x80–0xBF);
  - privileged and carrying any color other than black.
- R5: A privileged update with 0xFF stores black. A privileged lookup with 0xFF hits it. An unprivileged lookup with 0xFF always misses.
- R6: A speculative update (`up_spec`=1) stores the tag 0x80 + `up_ckpt` instead of the thread color. Lookups with the thread color miss it, and a lookup carrying a white value always misses.
- R7: A resolve with `rs_accept`=1 recolors every entry holding 0x80 + `rs_ckpt` to the color of the most recent speculative update to that checkpoint. Those entries then hit for that color.
- R8: A resolve with `rs_accept`=0 recolors every entry holding 0x80 + `rs_ckpt` to 0x00. Such entries never hit, and a lookup carrying 0x00 never hits.
- R9: A resolve changes only entries holding its own checkpoint's white variant. Entries of other outstanding checkpoints remain white.
- R10: A lookup in the same cycle as a resolve sees the colors from before the resolve.
- R11: When an update and a resolve touch the same entry in one cycle, the update's color and value are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | IDX_W | Lookup index |
| lk_color | input | 8 | Requester color |
| lk_priv | input | 1 | Requester is in privileged mode |
| lk_hit | output | 1 | Registered lookup hit |
| lk_value | output | VAL_W | Registered value on hit, 0 on miss |
| up_valid | input | 1 | Update request |
| up_idx | input | IDX_W | Update index |
| up_value | input | VAL_W | Value to store |
| up_color | input | 8 | Updating thread color |
| up_priv | input | 1 | Updater is in privileged mode |
| up_spec | input | 1 | Update is speculative |
| up_ckpt | input | CKPT_W | Checkpoint of a speculative update |
| up_err | output | 1 | One-cycle pulse for a rejected update |
| rs_valid | input | 1 | Resolve broadcast |
| rs_ckpt | input | CKPT_W | Checkpoint being resolved |
| rs_accept | input | 1 | 1 accept, 0 reject |

## Verification
The hardest situations to reach are the ones where several things land in the same cycle. One is a resolve arriving together with a lookup of the entry it recolors. The other is a resolve arriving together with an update that overwrites a white entry. The stimulus table builds both cases step by step:
- It first parks entries under two separate white variants.
- It then issues the resolve in the same vector as the competing lookup or update.
- In the following vectors it probes each entry with the owner color, so the pre-resolve view, the winning write and the untouched second checkpoint all become visible at the lookup port.

// File: rtl/hue_pkg.sv
package hue_pkg;
   localparam int HUE_W = 8;
   typedef logic [HUE_W-1:0] hue_t;

   localparam hue_t HUE_CLEAN      = 8'h00;
   localparam hue_t HUE_BLACK      = 8'hFF;
   localparam hue_t HUE_WHITE_BASE = 8'h80;
   localparam int   WHITE_SPAN     = 64;

   function automatic logic hue_is_white(hue_t c);
      return c[7:6] == 2'b10;
   endfunction

   function automatic logic hue_is_thread(hue_t c);
      return (c != HUE_CLEAN) && (c != HUE_BLACK) && !hue_is_white(c);
   endfunction

   // privileged requesters must present black, others a thread color
   function automatic logic hue_legal(hue_t c, logic priv);
      return priv ? (c == HUE_BLACK) : hue_is_thread(c);
   endfunction

   function automatic hue_t hue_white_of(logic [5:0] ck);
      return HUE_WHITE_BASE | {2'b00, ck};
   endfunction
endpackage

// File: rtl/hue_update_gate.sv
module hue_update_gate
   import hue_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int VAL_W  = 8,
   parameter int CKPT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic [IDX_W-1:0]  up_idx,
   input  logic [VAL_W-1:0]  up_value,
   input  hue_t              up_color,
   input  logic              up_priv,
   input  logic              up_spec,
   input  logic [CKPT_W-1:0] up_ckpt,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [VAL_W-1:0]  wr_value,
   output hue_t              wr_color,
   output logic              own_we,
   output logic [CKPT_W-1:0] own_ckpt,
   output hue_t              own_color,
   output logic              up_err
);
   logic legal;
   logic err_q;

   always_comb begin
      legal     = hue_legal(up_color, up_priv);
      wr_en     = up_valid && legal;
      wr_idx    = up_idx;
      wr_value  = up_value;
      wr_color  = up_spec ? hue_white_of(6'(up_ckpt)) : up_color;
      own_we    = wr_en && up_spec;
      own_ckpt  = up_ckpt;
      own_color = up_color;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= up_valid && !legal;
   end

   assign up_err = err_q;
endmodule

// File: rtl/hue_owner_file.sv
module hue_owner_file
   import hue_pkg::*;
#(
   parameter int CKPT_N = 8,
   localparam int CKPT_W = $clog2(CKPT_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CKPT_W-1:0] wr_ckpt,
   input  hue_t              wr_color,
   input  logic [CKPT_W-1:0] rd_ckpt,
   output hue_t              rd_color
);
   hue_t [CKPT_N-1:0] owner;

   for (genvar k = 0; k < CKPT_N; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            owner[k] <= HUE_CLEAN;
         else if (we && (wr_ckpt == CKPT_W'(k)))
            owner[k] <= wr_color;
      end
   end

   assign rd_color = owner[rd_ckpt];
endmodule

// File: rtl/hue_entry_array.sv
module hue_entry_array
   import hue_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VAL_W   = 8,
   parameter int CKPT_W  = 3,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [VAL_W-1:0]              wr_value,
   input  hue_t                          wr_color,
   input  logic                          rs_valid,
   input  logic [CKPT_W-1:0]             rs_ckpt,
   input  logic                          rs_accept,
   input  hue_t                          rs_owner,
   output hue_t [ENTRIES-1:0]            colors,
   output logic [ENTRIES-1:0][VAL_W-1:0] values
);
   hue_t rs_white;
   hue_t rs_new;

   always_comb begin
      rs_white = hue_white_of(6'(rs_ckpt));
      rs_new   = rs_accept ? rs_owner : HUE_CLEAN;
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      hue_t             c_q;
      logic [VAL_W-1:0] v_q;
      logic             sel_wr;
      logic             sel_rs;

      assign sel_wr = wr_en && (wr_idx == IDX_W'(e));
      assign sel_rs = rs_valid && (c_q == rs_white);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_q <= HUE_CLEAN;
            v_q <= '0;
         end else if (sel_wr) begin
            c_q <= wr_color;
            v_q <= wr_value;
         end else if (sel_rs) begin
            c_q <= rs_new;
         end
      end

      assign colors[e] = c_q;
      assign values[e] = v_q;
   end
endmodule

// File: rtl/hue_lookup.sv
module hue_lookup
   import hue_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VAL_W   = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          lk_valid,
   input  logic [IDX_W-1:0]              lk_idx,
   input  hue_t                          lk_color,
   input  logic                          lk_priv,
   input  hue_t [ENTRIES-1:0]            colors,
   input  logic [ENTRIES-1:0][VAL_W-1:0] values,
   output logic                          lk_hit,
   output logic [VAL_W-1:0]              lk_value
);
   logic             hit_c;
   logic             hit_q;
   logic [VAL_W-1:0] val_q;

   always_comb begin
      hit_c = lk_valid && hue_legal(lk_color, lk_priv) && (colors[lk_idx] == lk_color);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q <= 1'b0;
         val_q <= '0;
      end else begin
         hit_q <= hit_c;
         val_q <= hit_c ? values[lk_idx] : '0;
      end
   end

   assign lk_hit   = hit_q;
   assign lk_value = val_q;
endmodule

// File: rtl/hue_pred_table.sv
module hue_pred_table
   import hue_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VAL_W   = 8,
   parameter int CKPT_N  = 8,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int CKPT_W = $clog2(CKPT_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic [7:0]        lk_color,
   input  logic              lk_priv,
   output logic              lk_hit,
   output logic [VAL_W-1:0]  lk_value,
   input  logic              up_valid,
   input  logic [IDX_W-1:0]  up_idx,
   input  logic [VAL_W-1:0]  up_value,
   input  logic [7:0]        up_color,
   input  logic              up_priv,
   input  logic              up_spec,
   input  logic [CKPT_W-1:0] up_ckpt,
   output logic              up_err,
   input  logic              rs_valid,
   input  logic [CKPT_W-1:0] rs_ckpt,
   input  logic              rs_accept
);
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("hue_pred_table: ENTRIES must be a power of two of at least 2");
   end
   if (CKPT_N < 2 || CKPT_N > WHITE_SPAN || (CKPT_N & (CKPT_N - 1)) != 0) begin : g_bad_ckpt
      $error("hue_pred_table: CKPT_N must be a power of two in 2..64");
   end
   if (VAL_W < 1) begin : g_bad_val
      $error("hue_pred_table: VAL_W must be positive");
   end

   logic                          wr_en;
   logic [IDX_W-1:0]              wr_idx;
   logic [VAL_W-1:0]              wr_value;
   hue_t                          wr_color;
   logic                          own_we;
   logic [CKPT_W-1:0]             own_ckpt;
   hue_t                          own_color;
   hue_t                          rs_owner;
   hue_t [ENTRIES-1:0]            colors;
   logic [ENTRIES-1:0][VAL_W-1:0] values;

   hue_update_gate #(.IDX_W(IDX_W), .VAL_W(VAL_W), .CKPT_W(CKPT_W)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_idx(up_idx), .up_value(up_value),
      .up_color(up_color), .up_priv(up_priv), .up_spec(up_spec), .up_ckpt(up_ckpt),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value), .wr_color(wr_color),
      .own_we(own_we), .own_ckpt(own_ckpt), .own_color(own_color),
      .up_err(up_err)
   );

   hue_owner_file #(.CKPT_N(CKPT_N)) u_owner (
      .clk(clk), .rst_n(rst_n),
      .we(own_we), .wr_ckpt(own_ckpt), .wr_color(own_color),
      .rd_ckpt(rs_ckpt), .rd_color(rs_owner)
   );

   hue_entry_array #(.ENTRIES(ENTRIES), .VAL_W(VAL_W), .CKPT_W(CKPT_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value), .wr_color(wr_color),
      .rs_valid(rs_valid), .rs_ckpt(rs_ckpt), .rs_accept(rs_accept), .rs_owner(rs_owner),
      .colors(colors), .values(values)
   );

   hue_lookup #(.ENTRIES(ENTRIES), .VAL_W(VAL_W)) u_lookup (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_color(lk_color), .lk_priv(lk_priv),
      .colors(colors), .values(values),
      .lk_hit(lk_hit), .lk_value(lk_value)
   );
endmodule

// File: rtl/hue_pred_table_chk.sv
module hue_pred_table_chk #(
   parameter int VAL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic [7:0]       lk_color,
   input logic             lk_priv,
   input logic             lk_hit,
   input logic [VAL_W-1:0] lk_value,
   input logic             up_valid,
   input logic [7:0]       up_color,
   input logic             up_priv,
   input logic             up_err
);
   // R4
   black_unpriv_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_priv && up_color == 8'hFF) |=> up_err);

   // R4
   err_needs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> !up_err);

   // R5
   black_unpriv_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_priv && lk_color == 8'hFF) |=> !lk_hit);

   // R6
   white_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_color[7:6] == 2'b10) |=> !lk_hit);

   // R8
   clean_lookup_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_color == 8'h00) |=> !lk_hit);

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!lk_hit && lk_value == '0));
endmodule

bind hue_pred_table hue_pred_table_chk #(.VAL_W(VAL_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lk_valid(lk_valid), .lk_color(lk_color), .lk_priv(lk_priv),
   .lk_hit(lk_hit), .lk_value(lk_value),
   .up_valid(up_valid), .up_color(up_color), .up_priv(up_priv),
   .up_err(up_err)
);

// File: tb/hue_pred_table_test.sv
`timescale 1ns/1ps
module hue_pred_table_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lk_valid = 1'b0;
   logic [3:0] lk_idx = '0;
   logic [7:0] lk_color = '0;
   logic       lk_priv = 1'b0;
   logic       lk_hit;
   logic [7:0] lk_value;
   logic       up_valid = 1'b0;
   logic [3:0] up_idx = '0;
   logic [7:0] up_value = '0;
   logic [7:0] up_color = '0;
   logic       up_priv = 1'b0;
   logic       up_spec = 1'b0;
   logic [2:0] up_ckpt = '0;
   logic       up_err;
   logic       rs_valid = 1'b0;
   logic [2:0] rs_ckpt = '0;
   logic       rs_accept = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   hue_pred_table uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_color(lk_color), .lk_priv(lk_priv),
      .lk_hit(lk_hit), .lk_value(lk_value),
      .up_valid(up_valid), .up_idx(up_idx), .up_value(up_value), .up_color(up_color),
      .up_priv(up_priv), .up_spec(up_spec), .up_ckpt(up_ckpt), .up_err(up_err),
      .rs_valid(rs_valid), .rs_ckpt(rs_ckpt), .rs_accept(rs_accept)
   );

   typedef struct packed {
      logic       uv; logic [3:0] ui; logic [7:0] uval; logic [7:0] ucol;
      logic       up; logic us; logic [2:0] uc;
      logic       lv; logic [3:0] li; logic [7:0] lc; logic lp;
      logic       rv; logic [2:0] rc; logic ra;
      logic       eh; logic [7:0] ev; logic ee;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 30;
   // fields: update(v,idx,val,color,priv,spec,ckpt) lookup(v,idx,color,priv)
   //         resolve(v,ckpt,accept) expect(hit,value,err) requirement
   localparam vec_t VECS [NV] = '{
      // R2 plain write, then hit
      '{1'b1,4'd3,8'hA5,8'h11,1'b0,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd2},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd3,8'h11,1'b0, 1'b0,3'd0,1'b0, 1'b1,8'hA5,1'b0, 4'd2},
      // R3 other thread misses
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd3,8'h22,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd3},
      // R4 illegal updates rejected, entry unchanged
      '{1'b1,4'd3,8'h77,8'hFF,1'b0,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b1, 4'd4},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd3,8'h11,1'b0, 1'b0,3'd0,1'b0, 1'b1,8'hA5,1'b0, 4'd4},
      '{1'b1,4'd4,8'h66,8'h11,1'b1,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b1, 4'd4},
      '{1'b1,4'd4,8'h66,8'h00,1'b0,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b1, 4'd4},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd4,8'h11,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd4},
      // R5 privileged black
      '{1'b1,4'd5,8'h3C,8'hFF,1'b1,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd5},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd5,8'hFF,1'b1, 1'b0,3'd0,1'b0, 1'b1,8'h3C,1'b0, 4'd5},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd5,8'hFF,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd5},
      // R6 / R9 speculative writes under two checkpoints
      '{1'b1,4'd7,8'h42,8'h22,1'b0,1'b1,3'd2, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd6},
      '{1'b1,4'd8,8'h43,8'h22,1'b0,1'b1,3'd3, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd9},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd7,8'h22,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd6},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd7,8'h82,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd6},
      // R10 lookup alongside accept sees white
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd7,8'h22,1'b0, 1'b1,3'd2,1'b1, 1'b0,8'h00,1'b0, 4'd10},
      // R7 accepted entry now hits
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd7,8'h22,1'b0, 1'b0,3'd0,1'b0, 1'b1,8'h42,1'b0, 4'd7},
      // R9 checkpoint 3 untouched
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd8,8'h22,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd9},
      // R8 reject checkpoint 3
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b1,3'd3,1'b0, 1'b0,8'h00,1'b0, 4'd8},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd8,8'h22,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd8},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd8,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd8},
      // R11 update beats resolve on the same entry
      '{1'b1,4'd9,8'h11,8'h44,1'b0,1'b1,3'd4, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd11},
      '{1'b1,4'd9,8'h12,8'h55,1'b0,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b1,3'd4,1'b1, 1'b0,8'h00,1'b0, 4'd11},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd9,8'h55,1'b0, 1'b0,3'd0,1'b0, 1'b1,8'h12,1'b0, 4'd11},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd9,8'h44,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd11},
      // R7 accept recolors every entry of the checkpoint
      '{1'b1,4'd10,8'h20,8'h66,1'b0,1'b1,3'd1, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd7},
      '{1'b1,4'd11,8'h21,8'h66,1'b0,1'b1,3'd1, 1'b0,4'd0,8'h00,1'b0, 1'b0,3'd0,1'b0, 1'b0,8'h00,1'b0, 4'd7},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b0,4'd0,8'h00,1'b0, 1'b1,3'd1,1'b1, 1'b0,8'h00,1'b0, 4'd7},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd10,8'h66,1'b0, 1'b0,3'd0,1'b0, 1'b1,8'h20,1'b0, 4'd7},
      '{1'b0,4'd0,8'h00,8'h00,1'b0,1'b0,3'd0, 1'b1,4'd11,8'h66,1'b0, 1'b0,3'd0,1'b0, 1'b1,8'h21,1'b0, 4'd7}
   };

   task automatic check(string what, int req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      up_valid = 1'b0; lk_valid = 1'b0; rs_valid = 1'b0;
      up_spec = 1'b0; up_priv = 1'b0; lk_priv = 1'b0;
   endtask

   task automatic apply(vec_t v);
      up_valid = v.uv; up_idx = v.ui; up_value = v.uval; up_color = v.ucol;
      up_priv = v.up; up_spec = v.us; up_ckpt = v.uc;
      lk_valid = v.lv; lk_idx = v.li; lk_color = v.lc; lk_priv = v.lp;
      rs_valid = v.rv; rs_ckpt = v.rc; rs_accept = v.ra;
   endtask

   task automatic probe(logic [3:0] idx, logic [7:0] col, logic pv, int req);
      lk_valid = 1'b1; lk_idx = idx; lk_color = col; lk_priv = pv;
      @(posedge clk); @(negedge clk);
      check("hit after reset", req, 32'(lk_hit), 32'd0);
      check("value after reset", req, 32'(lk_value), 32'd0);
      lk_valid = 1'b0;
   endtask

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      // R1 reset state seen at the ports
      check("err in reset", 1, 32'(up_err), 32'd0);
      check("hit in reset", 1, 32'(lk_hit), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 16; i++) probe(4'(i), 8'h11, 1'b0, 1);
      probe(4'd0, 8'hFF, 1'b1, 1);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(posedge clk); @(negedge clk);
         check($sformatf("vec %0d hit", i), int'(VECS[i].req), 32'(lk_hit), 32'(VECS[i].eh));
         check($sformatf("vec %0d value", i), int'(VECS[i].req), 32'(lk_value), 32'(VECS[i].ev));
         check($sformatf("vec %0d err", i), int'(VECS[i].req), 32'(up_err), 32'(VECS[i].ee));
      end
      idle_inputs();
      @(posedge clk); @(negedge clk);
      // R4 error is a single pulse
      check("err idle", 4, 32'(up_err), 32'd0);

      // R1 reset mid-run clears trained entries
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      probe(4'd3, 8'h11, 1'b0, 1);
      probe(4'd5, 8'hFF, 1'b1, 1);
      probe(4'd9, 8'h55, 1'b0, 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R0 watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule